// File: doc/BRIEF.md
# Indirect Register Port for a Network Controller

This block is the slave-side register front end of a network controller, reached through a 16-bit I/O window. Software first writes an index register, then moves data through one of two data ports. One port opens the control/status space and the other opens the bus configuration space. A read at a fourth offset returns the controller to its reset state.

The block holds the command/status word with its init, start, stop, transmit-demand and init-done bits. It also holds the 32-bit init-block address, a set of plain read/write configuration registers and two read-only identification words. It issues a one-cycle init request to the init engine and a one-cycle poll pulse to the transmit engine. It drives a run enable for the transmit and receive engines and accepts an init-complete strobe back.

Top module: `nic_regport`

## Requirements
- R1: The port is picked by `io_addr`. 0x10 is the control/status data port, 0x12 is the index register, 0x14 is the reset port and 0x16 is the configuration data port. The index register keeps the low 8 bits of the last value written to it and reads back with bits 15:8 as 0, so writing 88 and reading it gives 88. A write to any other offset is ignored, and a read from one returns 0. Read data appears on `io_rdata` one cycle after the read strobe and holds until the next read.
- R2: A read at offset 0x14 returns 0 and brings every control/status and configuration register back to its reset value. The index register is kept. Afterwards, control/status index 0 reads exactly 0x0004, which is the stop bit alone.
- R3: Control/status index 0 uses bit 0 for init, bit 1 for start, bit 2 for stop, bit 3 for transmit demand and bit 8 for init done. Writing 1 to bit 0 (with bit 2 at 0) sets the init bit and clears stop. It also raises `init_req` for exactly one cycle, starting the cycle after the write.
- R4: An `init_done` strobe, while the block is not stopped, sets bit 8 and clears the init bit. Writing 1 to bit 8 clears it. When a clear and the strobe arrive in the same cycle, the strobe wins. While stopped, the strobe is ignored.
- R5: Writing 1 to bit 1 (with bit 2 at 0) sets start, clears stop and drives `run_en` high.
- R6: Writing 1 to bit 2 sets stop and clears init, start and init done. It takes priority over bits 0, 1 and 3 written in the same word, so no `init_req` or `tx_poll` follows, and it drops `run_en`.
- R7: Writing 1 to bit 3 gives a one-cycle `tx_poll` pulse in the cycle after the write, unless the block is stopped once that write has taken effect. Bit 3 always reads back as 0.
- R8: Control/status indexes 1 and 2 hold the low and high halves of the init-block address. Both read back, and together they drive `init_blk_addr`.
- R9: Control/status indexes 88 and 89 are read-only and form a 32-bit identifier. Bits 11:0 are 0x003, bits 27:12 are `PART_CODE` and bits 31:28 are 0. With the default 0x2625, index 88 reads 0x5003 and index 89 reads 0x0262. Writes to them are ignored.
- R10: Control/status indexes 4 and 80, and configuration indexes 2, 18, 20 and 32, keep the last 16-bit value written. The two spaces are separate, so configuration index 2 is not control/status index 2.
- R11: A write to an unimplemented index in either space changes nothing, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Offset within the I/O window |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| init_done | input | 1 | Completion strobe from the init engine |
| init_req | output | 1 | One-cycle init request |
| tx_poll | output | 1 | One-cycle transmit poll |
| run_en | output | 1 | Transmit/receive engines enabled |
| init_blk_addr | output | 32 | Init-block address |

## Verification
Writes take effect at the clock edge that samples the strobe. The pulses and `run_en` are registers, so the bench checks them on the falling edge that follows that write edge. It then checks the pulses once more a cycle later to prove they last a single cycle. Read data is registered at the edge that samples the read strobe, so each read is checked on the next falling edge. A soft reset acts at that same edge, so the next read sees the reset values. Random index traffic in both spaces is compared against a bench model that only tracks the implemented indexes.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;
  localparam int DW    = 16;
  localparam int IDX_W = 8;
  localparam int AW    = 5;

  // Port select; ordinal equals io_addr[2:1] of the window offset.
  typedef enum logic [1:0] {
    PORT_CSR = 2'd0,
    PORT_IDX = 2'd1,
    PORT_RST = 2'd2,
    PORT_BCR = 2'd3
  } port_e;

  // Command word bit positions.
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IDON = 8;

  // Compact command vector passed to the command block.
  typedef struct packed {
    logic idon;
    logic tdmd;
    logic stop;
    logic strt;
    logic init;
  } cmd_t;

  localparam logic [IDX_W-1:0] IDX_CMD   = 8'd0;
  localparam logic [IDX_W-1:0] IDX_ID_LO = 8'd88;
  localparam logic [IDX_W-1:0] IDX_ID_HI = 8'd89;

  function automatic logic port_valid(input logic [AW-1:0] a);
    return a[4] && !a[3] && !a[0];
  endfunction
endpackage

// File: rtl/nic_rp_rstsync.sv
module nic_rp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nic_rp_regbank.sv
module nic_rp_regbank #(
  parameter int                     NUM      = 4,
  parameter int                     IDX_W    = 8,
  parameter int                     DW       = 16,
  parameter logic [NUM*IDX_W-1:0]   IDX_LIST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic             hit_o,
  output logic [DW-1:0]    rdata_o
);
  logic [NUM-1:0]    sel;
  logic [NUM*DW-1:0] q_flat;

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [DW-1:0] q, d;
    logic          en;
    assign sel[g] = (idx == IDX_LIST[g*IDX_W +: IDX_W]);
    always_comb begin
      en = srst | (wr_en & sel[g]);
      d  = srst ? '0 : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign q_flat[g*DW +: DW] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++)
      if (sel[i]) rdata_o = rdata_o | q_flat[i*DW +: DW];
    hit_o = |sel;
  end

  // R10: a written register holds what was written
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && hit_o && !srst) && $stable(idx) && !$past(srst, 1))
      |-> rdata_o == $past(wdata));
endmodule

// File: rtl/nic_rp_cmd.sv
module nic_rp_cmd
  import nic_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          wr_en,
  input  cmd_t          cmd,
  input  logic          init_done_i,
  output logic [DW-1:0] csr0_o,
  output logic          init_req_o,
  output logic          tx_poll_o,
  output logic          run_en_o
);
  logic init_q, strt_q, stop_q, idon_q, ireq_q, poll_q;
  logic init_n, strt_n, stop_n, idon_n, ireq_n, poll_n;

  always_comb begin
    init_n = init_q;
    strt_n = strt_q;
    stop_n = stop_q;
    idon_n = idon_q;
    if (wr_en) begin
      if (cmd.stop) begin
        stop_n = 1'b1;
        init_n = 1'b0;
        strt_n = 1'b0;
        idon_n = 1'b0;
      end else begin
        if (cmd.init) begin init_n = 1'b1; stop_n = 1'b0; end
        if (cmd.strt) begin strt_n = 1'b1; stop_n = 1'b0; end
        if (cmd.idon) idon_n = 1'b0;
      end
    end
    if (init_done_i && !stop_n) begin
      idon_n = 1'b1;
      init_n = 1'b0;
    end
    ireq_n = wr_en && cmd.init && !cmd.stop;
    poll_n = wr_en && cmd.tdmd && !stop_n;
    if (srst) begin
      init_n = 1'b0;
      strt_n = 1'b0;
      stop_n = 1'b1;
      idon_n = 1'b0;
      ireq_n = 1'b0;
      poll_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      strt_q <= 1'b0;
      stop_q <= 1'b1;
      idon_q <= 1'b0;
      ireq_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      init_q <= init_n;
      strt_q <= strt_n;
      stop_q <= stop_n;
      idon_q <= idon_n;
      ireq_q <= ireq_n;
      poll_q <= poll_n;
    end
  end

  always_comb begin
    csr0_o         = '0;
    csr0_o[B_INIT] = init_q;
    csr0_o[B_STRT] = strt_q;
    csr0_o[B_STOP] = stop_q;
    csr0_o[B_IDON] = idon_q;
  end

  assign init_req_o = ireq_q;
  assign tx_poll_o  = poll_q;
  assign run_en_o   = strt_q;

  // R3: the init request only follows an init write
  a_r3_ireq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_o |-> $past(wr_en && cmd.init));
  // R6: a stop write never yields an init request
  a_r6_stop_no_ireq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && cmd.stop) |-> !init_req_o && !tx_poll_o && !run_en_o);
  // R7: the poll only follows a transmit-demand write
  a_r7_poll_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll_o |-> $past(wr_en && cmd.tdmd));
  // R4: a completion strobe while running sets init done
  a_r4_idon_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done_i && !srst && !(wr_en && cmd.stop) && !stop_q) |-> csr0_o[B_IDON]);
  // R5: running and stopped are exclusive
  a_r5_run_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en_o && csr0_o[B_STOP]));
endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter logic [15:0] PART_CODE = 16'h2625
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic          init_done,
  output logic          init_req,
  output logic          tx_poll,
  output logic          run_en,
  output logic [31:0]   init_blk_addr
);
  localparam int CSR_N = 4;
  localparam int BCR_N = 4;
  localparam logic [CSR_N*IDX_W-1:0] CSR_LIST = {8'd80, 8'd4, 8'd2, 8'd1};
  localparam logic [BCR_N*IDX_W-1:0] BCR_LIST = {8'd32, 8'd20, 8'd18, 8'd2};
  localparam logic [31:0] CHIP_ID = {4'h0, PART_CODE, 12'h003};

  logic          rstn_s;
  logic          pv;
  port_e         port;
  logic          wr_csr, wr_bcr, wr_idx, rd_rst;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic [DW-1:0] csr0, csr_bank_rd, bcr_bank_rd;
  logic          csr_hit, bcr_hit, csr_any;
  logic          csr_bank_hit, bcr_bank_hit;
  logic          srst;
  cmd_t          cmd;

  nic_rp_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_s)
  );

  always_comb begin
    pv     = port_valid(io_addr);
    port   = port_e'(io_addr[2:1]);
    wr_csr = io_wr && pv && port == PORT_CSR;
    wr_bcr = io_wr && pv && port == PORT_BCR;
    wr_idx = io_wr && pv && port == PORT_IDX;
    rd_rst = io_rd && pv && port == PORT_RST;
    srst   = rd_rst;
    cmd.init = io_wdata[B_INIT];
    cmd.strt = io_wdata[B_STRT];
    cmd.stop = io_wdata[B_STOP];
    cmd.tdmd = io_wdata[B_TDMD];
    cmd.idon = io_wdata[B_IDON];
  end

  nic_rp_cmd u_cmd (
    .clk(clk), .rst_n(rstn_s), .srst(srst),
    .wr_en(wr_csr && idx_q == IDX_CMD), .cmd(cmd),
    .init_done_i(init_done), .csr0_o(csr0),
    .init_req_o(init_req), .tx_poll_o(tx_poll), .run_en_o(run_en)
  );

  nic_rp_regbank #(.NUM(CSR_N), .IDX_W(IDX_W), .DW(DW), .IDX_LIST(CSR_LIST)) u_csr (
    .clk(clk), .rst_n(rstn_s), .srst(srst), .wr_en(wr_csr), .idx(idx_q),
    .wdata(io_wdata), .hit_o(csr_bank_hit), .rdata_o(csr_bank_rd)
  );

  nic_rp_regbank #(.NUM(BCR_N), .IDX_W(IDX_W), .DW(DW), .IDX_LIST(BCR_LIST)) u_bcr (
    .clk(clk), .rst_n(rstn_s), .srst(srst), .wr_en(wr_bcr), .idx(idx_q),
    .wdata(io_wdata), .hit_o(bcr_bank_hit), .rdata_o(bcr_bank_rd)
  );

  // Init-block address comes from indexes 1 and 2 of the control space.
  logic [DW-1:0] addr_lo, addr_hi;
  assign addr_lo = u_csr.g_reg[0].q;
  assign addr_hi = u_csr.g_reg[1].q;
  assign init_blk_addr = {addr_hi, addr_lo};

  always_comb begin
    csr_hit = csr_bank_hit;
    bcr_hit = bcr_bank_hit;
    csr_any = csr_hit || idx_q == IDX_CMD || idx_q == IDX_ID_LO || idx_q == IDX_ID_HI;
    idx_n   = wr_idx ? io_wdata[IDX_W-1:0] : idx_q;
    rdata_n = '0;
    if (pv) begin
      unique case (port)
        PORT_IDX: rdata_n = {{(DW-IDX_W){1'b0}}, idx_q};
        PORT_CSR: begin
          if (idx_q == IDX_CMD)        rdata_n = csr0;
          else if (idx_q == IDX_ID_LO) rdata_n = CHIP_ID[15:0];
          else if (idx_q == IDX_ID_HI) rdata_n = CHIP_ID[31:16];
          else if (csr_hit)            rdata_n = csr_bank_rd;
        end
        PORT_BCR: if (bcr_hit) rdata_n = bcr_bank_rd;
        default:  rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) idx_q <= '0;
    else if (wr_idx) idx_q <= idx_n;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)    rdata_q <= '0;
    else if (io_rd) rdata_q <= rdata_n;
  end

  assign io_rdata = rdata_q;

  // R1: index read returns the held index
  a_r1_idx_readback: assert property (@(posedge clk) disable iff (!rstn_s)
    $past(io_rd && pv && port == PORT_IDX) |-> io_rdata == {{(DW-IDX_W){1'b0}}, $past(idx_q)});
  // R2: after a soft reset the command word is the stop bit alone
  a_r2_srst_state: assert property (@(posedge clk) disable iff (!rstn_s)
    $past(srst) |-> csr0 == 16'h0004 && io_rdata == '0 && init_blk_addr == '0);
  // R11: unimplemented control index reads 0
  a_r11_unimpl_zero: assert property (@(posedge clk) disable iff (!rstn_s)
    $past(io_rd && pv && port == PORT_CSR && !csr_any) |-> io_rdata == '0);
  // R11: unimplemented configuration index reads 0
  a_r11_unimpl_bcr: assert property (@(posedge clk) disable iff (!rstn_s)
    $past(io_rd && pv && port == PORT_BCR && !bcr_hit) |-> io_rdata == '0);
endmodule

// File: tb/nic_regport_tb.sv
module nic_regport_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  io_addr;
  logic        io_wr, io_rd, init_done;
  logic [15:0] io_wdata, io_rdata;
  logic        init_req, tx_poll, run_en;
  logic [31:0] init_blk_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [4:0] A_DATA = 5'h10, A_IDX = 5'h12, A_RST = 5'h14, A_BCFG = 5'h16;

  always #2 clk = ~clk;

  nic_regport u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .init_done(init_done),
    .init_req(init_req), .tx_poll(tx_poll), .run_en(run_en),
    .init_blk_addr(init_blk_addr)
  );

  logic [15:0] m_csr [0:255];
  logic [15:0] m_bcr [0:255];

  function automatic bit csr_rw(input int i);
    return i == 1 || i == 2 || i == 4 || i == 80;
  endfunction
  function automatic bit bcr_rw(input int i);
    return i == 2 || i == 18 || i == 20 || i == 32;
  endfunction
  function automatic logic [15:0] exp_csr(input int i);
    if (csr_rw(i)) return m_csr[i];
    if (i == 88)   return 16'h5003;
    if (i == 89)   return 16'h0262;
    return 16'h0000;
  endfunction
  function automatic logic [15:0] exp_bcr(input int i);
    return bcr_rw(i) ? m_bcr[i] : 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rd_csr(input int i, output logic [15:0] d);
    io_write(A_IDX, 16'(i));
    io_read(A_DATA, d);
  endtask

  task automatic rd_bcr(input int i, output logic [15:0] d);
    io_write(A_IDX, 16'(i));
    io_read(A_BCFG, d);
  endtask

  task automatic pulse_done();
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 256; i++) begin m_csr[i] = '0; m_bcr[i] = '0; end
    io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0; init_done = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    io_read(A_DATA, r);  chk("R2 reset csr0", r, 16'h0004);
    chk("R5 reset run_en", run_en, 0);
    chk("R8 reset addr", init_blk_addr, 0);

    // index readback
    io_write(A_IDX, 16'd88); io_read(A_IDX, r); chk("R1 index 88", r, 16'd88);
    io_write(A_IDX, 16'hFF3C); io_read(A_IDX, r); chk("R1 index low byte", r, 16'h003C);

    // identification
    rd_csr(88, r); chk("R9 id lo", r, 16'h5003);
    rd_csr(89, r); chk("R9 id hi", r, 16'h0262);
    io_write(A_IDX, 16'd88); io_write(A_DATA, 16'hFFFF);
    io_read(A_DATA, r); chk("R11 id write ignored", r, 16'h5003);

    // init block address
    io_write(A_IDX, 16'd1); io_write(A_DATA, 16'hBEEF); m_csr[1] = 16'hBEEF;
    io_write(A_IDX, 16'd2); io_write(A_DATA, 16'h1234); m_csr[2] = 16'h1234;
    chk("R8 init_blk_addr", init_blk_addr, 32'h1234BEEF);
    rd_csr(1, r); chk("R8 addr lo readback", r, 16'hBEEF);

    // init sequence
    io_write(A_IDX, 16'd0);
    io_write(A_DATA, 16'h0001);
    chk("R3 init_req high", init_req, 1);
    @(negedge clk); chk("R3 init_req one cycle", init_req, 0);
    io_read(A_DATA, r); chk("R3 csr0 after init", r, 16'h0001);

    // done strobe coinciding with a clear: strobe wins
    @(negedge clk);
    io_addr = A_DATA; io_wdata = 16'h0100; io_wr = 1'b1; init_done = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; init_done = 1'b0;
    io_read(A_DATA, r); chk("R4 set wins", r, 16'h0100);
    io_write(A_DATA, 16'h0100);
    io_read(A_DATA, r); chk("R4 write-one clear", r, 16'h0000);
    pulse_done();
    io_read(A_DATA, r); chk("R4 done sets", r, 16'h0100);
    io_write(A_DATA, 16'h0100);

    // start
    io_write(A_DATA, 16'h0002);
    chk("R5 run_en", run_en, 1);
    io_read(A_DATA, r); chk("R5 csr0 start", r, 16'h0002);

    // transmit demand
    io_write(A_DATA, 16'h0008);
    chk("R7 tx_poll high", tx_poll, 1);
    @(negedge clk); chk("R7 tx_poll one cycle", tx_poll, 0);
    io_read(A_DATA, r); chk("R7 tdmd reads 0", r, 16'h0002);

    // stop priority
    io_write(A_DATA, 16'h010F);
    chk("R6 no init_req", init_req, 0);
    chk("R6 no tx_poll", tx_poll, 0);
    chk("R6 run_en low", run_en, 0);
    io_read(A_DATA, r); chk("R6 csr0 stop", r, 16'h0004);
    io_write(A_DATA, 16'h0008);
    chk("R7 poll suppressed when stopped", tx_poll, 0);
    pulse_done();
    io_read(A_DATA, r); chk("R4 done ignored when stopped", r, 16'h0004);

    // unimplemented index
    io_write(A_IDX, 16'd50); io_write(A_DATA, 16'hAAAA);
    io_read(A_DATA, r); chk("R11 csr unimpl", r, 16'h0000);
    io_write(A_IDX, 16'd7); io_write(A_BCFG, 16'h5555);
    io_read(A_BCFG, r); chk("R11 bcr unimpl", r, 16'h0000);
    chk("R11 addr untouched", init_blk_addr, 32'h1234BEEF);

    // separate spaces
    io_write(A_IDX, 16'd2); io_write(A_BCFG, 16'h2222); m_bcr[2] = 16'h2222;
    io_read(A_DATA, r); chk("R10 csr2 separate", r, 16'h1234);
    io_read(A_BCFG, r); chk("R10 bcr2 kept", r, 16'h2222);

    // unmapped offset
    io_write(5'h00, 16'hFFFF);
    io_read(5'h00, r); chk("R1 unmapped offset", r, 16'h0000);
    io_read(A_IDX, r); chk("R1 index unchanged", r, 16'd2);

    // random traffic
    for (int n = 0; n < 300; n++) begin
      int pick, ix;
      bit bspace, dowr;
      logic [15:0] d;
      pick   = $urandom_range(0, 9);
      bspace = $urandom_range(0, 1);
      dowr   = $urandom_range(0, 1);
      d      = 16'($urandom);
      case (pick)
        0: ix = 1;  1: ix = 2;  2: ix = 4;  3: ix = 80;  4: ix = 88;
        5: ix = 89; 6: ix = 18; 7: ix = 20; 8: ix = 32;
        default: ix = $urandom_range(1, 255);
      endcase
      io_write(A_IDX, 16'(ix));
      if (dowr) begin
        if (bspace) begin
          io_write(A_BCFG, d);
          if (bcr_rw(ix)) m_bcr[ix] = d;
        end else begin
          io_write(A_DATA, d);
          if (csr_rw(ix)) m_csr[ix] = d;
        end
      end
      if (bspace) begin io_read(A_BCFG, r); chk("R10 random bcr", r, exp_bcr(ix)); end
      else begin io_read(A_DATA, r); chk("R11 random csr", r, exp_csr(ix)); end
    end

    // soft reset
    io_write(A_IDX, 16'd0); io_write(A_DATA, 16'h0002);
    io_write(A_IDX, 16'd18); io_write(A_BCFG, 16'h0BAD);
    io_write(A_IDX, 16'd1); io_write(A_DATA, 16'h7777);
    io_read(A_RST, r); chk("R2 reset read value", r, 16'h0000);
    chk("R2 run_en cleared", run_en, 0);
    chk("R2 addr cleared", init_blk_addr, 0);
    io_read(A_IDX, r); chk("R2 index kept", r, 16'd1);
    rd_bcr(18, r); chk("R2 bcr cleared", r, 16'h0000);
    rd_csr(0, r); chk("R2 csr0 stop only", r, 16'h0004);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule